// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block sends asynchronous serial frames out of a single line. The host writes a byte into a one-entry holding register. As soon as the shifter is free and a bit-rate tick arrives, that entry moves into the shift stage, and the holding register is free for the next byte. Because the two stages work on their own, the host can reload while a frame is still going out, and the frames then follow one another with no idle gap.

A frame has a low start bit, eight data bits sent least significant bit first, an optional ninth bit, and a high stop bit. Every bit lasts a fixed number of ticks of an external bit-rate strobe. The block does not compute parity. The host supplies any ninth-bit value, such as a parity or address flag, through a small register that must be written before the byte it belongs to.

The host sees two flags. One says the holding register is free, and it can raise an interrupt request. The other says the shifter has finished, and it never interrupts. A transmit-enable input gates the whole block. When it is deasserted, the transmitter resets at once and the line driver is released through a separate output-enable.

Top module: `sertx_dbuf`

## Requirements
- R1: After reset, and whenever the block is enabled with the shifter empty, `tx_o` is 1, `hold_empty_o` is 1 after reset and `shift_empty_o` is 1.
- R2: A frame is a 0 start bit, then `wr_data_i` bit 0 up to bit 7, then (9-bit mode only) the ninth bit, then a 1 stop bit. Each bit holds for exactly 16 ticks, and `tx_o` changes only on clock edges where `tick_i` is 1.
- R3: A write (`wr_valid_i`=1) is accepted only when `hold_empty_o`=1 and `tx_en_i`=1. Any other write is ignored and produces no frame.
- R4: The holding entry moves to the shifter on the first edge with `tick_i`=1 where the shifter is idle or is ending its stop bit. `hold_empty_o` rises on that edge, and a frame queued during another frame starts with no idle bit between them.
- R5: `hold_empty_o` falls only on the edge that accepts a write. No other input clears it.
- R6: `shift_empty_o` falls on the handoff edge, when the start bit begins, and rises only after the stop bit's last tick.
- R7: `irq_o` is `hold_empty_o` gated by `irq_en_i`. The shifter-empty status never drives it.
- R8: `nine_wr_i`=1 stores `nine_val_i` as the pending ninth bit. The pending ninth bit and `nine_mode_i` are captured with the byte at write time, so changes made after the write do not alter that frame. The ninth bit is sent exactly as supplied.
- R9: With `tx_en_i`=0, `tx_oe_o` is 0 at once. On the next edge the frame in progress and the holding entry are discarded (both empty flags 1). After re-enable the line idles high and the discarded frame does not resume.
- R10: In 8-bit mode (`nine_mode_i`=0 at write), the stop bit follows data bit 7 directly, giving a 10-bit frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | Bit-rate strobe, 16 per bit |
| tx_en_i | input | 1 | Transmit enable; 0 resets the transmitter |
| wr_valid_i | input | 1 | Load strobe for the holding register |
| wr_data_i | input | 8 | Byte to send |
| nine_wr_i | input | 1 | Write strobe for the pending ninth bit |
| nine_val_i | input | 1 | Ninth-bit value to store |
| nine_mode_i | input | 1 | 1 selects 11-bit frames with a ninth bit |
| irq_en_i | input | 1 | Interrupt enable for holding-empty |
| tx_o | output | 1 | Serial line level |
| tx_oe_o | output | 1 | Line driver enable (0 = high impedance) |
| hold_empty_o | output | 1 | Holding register free |
| shift_empty_o | output | 1 | Shifter idle |
| irq_o | output | 1 | Holding-empty interrupt request |

## Verification
A line decoder samples every bit at its middle tick and compares it with frames queued at write time. This catches bit-order, length and ninth-bit errors. Directed runs use a steady tick, so the start-to-start spacing of back-to-back frames must be exactly 160 cycles, which separates a gapless handoff from one that wastes a bit. One directed run writes a third byte into a full holding register and expects it to be dropped. Another changes the pending ninth bit right after a load to show that the value is captured at write time, and a third disables the block mid-frame. Random runs mix dense and sparse tick patterns, both frame lengths and random ninth-bit values, so that handoff timing that only works with a steady tick is exposed.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int unsigned DW    = 8;
    localparam int unsigned IDX_W = 4;
    localparam int unsigned DIW   = $clog2(DW);

    typedef struct packed {
        logic          nine_mode;
        logic          ninth;
        logic [DW-1:0] data;
    } frame_t;

    // Index of the stop bit inside a frame (start bit is index 0).
    function automatic logic [IDX_W-1:0] stop_idx(input frame_t f);
        return f.nine_mode ? IDX_W'(DW + 2) : IDX_W'(DW + 1);
    endfunction

    // Line level for bit position idx of frame f.
    function automatic logic line_level(input frame_t f, input logic [IDX_W-1:0] idx);
        logic lvl;
        if (idx == '0)
            lvl = 1'b0;
        else if (idx <= IDX_W'(DW))
            lvl = f.data[DIW'(idx - IDX_W'(1))];
        else if (idx == IDX_W'(DW + 1))
            lvl = f.nine_mode ? f.ninth : 1'b1;
        else
            lvl = 1'b1;
        return lvl;
    endfunction

endpackage

// File: rtl/sertx_hold.sv
module sertx_hold
    import sertx_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          wr_valid,
    input  logic [DW-1:0] wr_data,
    input  logic          nine_wr,
    input  logic          nine_val,
    input  logic          nine_mode,
    input  logic          take,
    output logic          full,
    output frame_t        frame
);

    logic nine_q;

    always_ff @(posedge clk) begin
        if (rst)
            nine_q <= 1'b0;
        else if (nine_wr)
            nine_q <= nine_val;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            full  <= 1'b0;
            frame <= '0;
        end else if (take) begin
            full <= 1'b0;
        end else if (wr_valid && !full) begin
            full            <= 1'b1;
            frame.data      <= wr_data;
            frame.ninth     <= nine_q;
            frame.nine_mode <= nine_mode;
        end
    end

endmodule

// File: rtl/sertx_bit_timer.sv
module sertx_bit_timer #(
    parameter int unsigned OVS = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic restart,
    input  logic tick,
    output logic bit_end
);

    localparam int unsigned SW = (OVS > 1) ? $clog2(OVS) : 1;
    localparam logic [SW-1:0] LAST = SW'(OVS - 1);

    logic [SW-1:0] sub;

    always_ff @(posedge clk) begin
        if (rst || !run || restart)
            sub <= '0;
        else if (tick)
            sub <= (sub == LAST) ? '0 : sub + 1'b1;
    end

    assign bit_end = run && tick && (sub == LAST);

endmodule

// File: rtl/sertx_shift.sv
module sertx_shift
    import sertx_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   en,
    input  logic   tick,
    input  logic   hold_full,
    input  frame_t hold_frame,
    input  logic   bit_end,
    output logic   take,
    output logic   busy,
    output logic   line
);

    frame_t           cur;
    logic [IDX_W-1:0] idx;
    logic             at_stop_end;

    assign at_stop_end = bit_end && (idx == stop_idx(cur));
    assign take        = en && tick && hold_full && (!busy || at_stop_end);

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            busy <= 1'b0;
            idx  <= '0;
            cur  <= '0;
        end else if (take) begin
            busy <= 1'b1;
            idx  <= '0;
            cur  <= hold_frame;
        end else if (bit_end) begin
            if (at_stop_end)
                busy <= 1'b0;
            else
                idx <= idx + 1'b1;
        end
    end

    assign line = busy ? line_level(cur, idx) : 1'b1;

endmodule

// File: rtl/sertx_dbuf.sv
module sertx_dbuf
    import sertx_pkg::*;
#(
    parameter int unsigned OVS = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick_i,
    input  logic          tx_en_i,
    input  logic          wr_valid_i,
    input  logic [DW-1:0] wr_data_i,
    input  logic          nine_wr_i,
    input  logic          nine_val_i,
    input  logic          nine_mode_i,
    input  logic          irq_en_i,
    output logic          tx_o,
    output logic          tx_oe_o,
    output logic          hold_empty_o,
    output logic          shift_empty_o,
    output logic          irq_o
);

    logic   hold_full;
    frame_t hold_frame;
    logic   take;
    logic   busy;
    logic   bit_end;
    logic   line;

    sertx_hold u_hold (
        .clk       (clk),
        .rst       (rst),
        .en        (tx_en_i),
        .wr_valid  (wr_valid_i),
        .wr_data   (wr_data_i),
        .nine_wr   (nine_wr_i),
        .nine_val  (nine_val_i),
        .nine_mode (nine_mode_i),
        .take      (take),
        .full      (hold_full),
        .frame     (hold_frame)
    );

    sertx_bit_timer #(.OVS(OVS)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .run     (busy),
        .restart (take),
        .tick    (tick_i),
        .bit_end (bit_end)
    );

    sertx_shift u_shift (
        .clk        (clk),
        .rst        (rst),
        .en         (tx_en_i),
        .tick       (tick_i),
        .hold_full  (hold_full),
        .hold_frame (hold_frame),
        .bit_end    (bit_end),
        .take       (take),
        .busy       (busy),
        .line       (line)
    );

    assign tx_o          = line;
    assign tx_oe_o       = tx_en_i;
    assign hold_empty_o  = !hold_full;
    assign shift_empty_o = !busy;
    assign irq_o         = irq_en_i && !hold_full;

endmodule

// File: rtl/sertx_dbuf_chk.sv
module sertx_dbuf_chk (
    input logic clk,
    input logic rst,
    input logic tick_i,
    input logic tx_en_i,
    input logic wr_valid_i,
    input logic irq_en_i,
    input logic tx_o,
    input logic tx_oe_o,
    input logic hold_empty_o,
    input logic shift_empty_o,
    input logic irq_o
);

    assert_idle_high_R1: assert property (@(posedge clk) disable iff (rst)
        shift_empty_o |-> tx_o);

    assert_line_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
        tx_oe_o && $past(tx_en_i) && !$past(tick_i) |-> $stable(tx_o));

    assert_handoff_tick_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(hold_empty_o) && $past(tx_en_i) |-> $past(tick_i) && !shift_empty_o);

    assert_clear_by_write_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(hold_empty_o) |-> $past(wr_valid_i) && $past(tx_en_i));

    assert_start_low_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(shift_empty_o) |-> $past(tick_i) && !tx_o);

    assert_irq_gated_R7: assert property (@(posedge clk) disable iff (rst)
        !irq_en_i |-> !irq_o);

    assert_disable_reset_R9: assert property (@(posedge clk) disable iff (rst)
        !tx_en_i |=> hold_empty_o && shift_empty_o);

endmodule

bind sertx_dbuf sertx_dbuf_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .tick_i        (tick_i),
    .tx_en_i       (tx_en_i),
    .wr_valid_i    (wr_valid_i),
    .irq_en_i      (irq_en_i),
    .tx_o          (tx_o),
    .tx_oe_o       (tx_oe_o),
    .hold_empty_o  (hold_empty_o),
    .shift_empty_o (shift_empty_o),
    .irq_o         (irq_o)
);

// File: tb/sertx_dbuf_tb.sv
`timescale 1ns/1ps
module sertx_dbuf_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_i = 1'b0;
    logic       tx_en_i = 1'b1;
    logic       wr_valid_i = 1'b0;
    logic [7:0] wr_data_i = '0;
    logic       nine_wr_i = 1'b0;
    logic       nine_val_i = 1'b0;
    logic       nine_mode_i = 1'b0;
    logic       irq_en_i = 1'b0;
    logic       tx_o, tx_oe_o, hold_empty_o, shift_empty_o, irq_o;

    always #2 clk = ~clk;

    sertx_dbuf u_dut (
        .clk(clk), .rst(rst), .tick_i(tick_i), .tx_en_i(tx_en_i),
        .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i), .nine_wr_i(nine_wr_i),
        .nine_val_i(nine_val_i), .nine_mode_i(nine_mode_i), .irq_en_i(irq_en_i),
        .tx_o(tx_o), .tx_oe_o(tx_oe_o), .hold_empty_o(hold_empty_o),
        .shift_empty_o(shift_empty_o), .irq_o(irq_o)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int tick_mode = 0;
    logic nine_model = 1'b0;
    logic [9:0] exp_q[$];
    logic [9:0] cur;
    bit   mon_busy = 0;
    int   mcnt = 0;
    int   last_start = 0;
    int   prev_start = 0;
    int   n_frames = 0;
    bit   done = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic logic exp_bit(input logic [9:0] f, input int k);
        if (k == 0) return 1'b0;
        if (k <= 8) return f[k-1];
        if (k == 9) return f[9] ? f[8] : 1'b1;
        return 1'b1;
    endfunction

    function automatic int frame_len(input logic [9:0] f);
        return f[9] ? 11 : 10;
    endfunction

    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1;
        case (tick_mode)
            0:       tick_i = 1'b1;
            1:       tick_i = ($urandom % 2) == 0;
            default: tick_i = ($urandom % 4) == 0;
        endcase
    end

    // Line decoder: samples each bit at its 8th tick.
    always @(negedge clk) begin
        if (rst || !tx_oe_o) begin
            mon_busy = 0;
        end else begin
            if (!mon_busy && tx_o == 1'b0) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R3", "frame with nothing accepted", 1, 0);
                    cur = 10'h0FF;
                end else begin
                    cur = exp_q.pop_front();
                end
                mon_busy   = 1;
                mcnt       = 0;
                prev_start = last_start;
                last_start = cyc;
                n_frames++;
            end
            if (mon_busy) begin
                if (mcnt % 16 == 8)
                    chk(tx_o == exp_bit(cur, mcnt / 16),
                        (mcnt / 16 == 9 && cur[9]) ? "R8" : "R2",
                        $sformatf("bit %0d of frame %h", mcnt / 16, cur),
                        int'(tx_o), int'(exp_bit(cur, mcnt / 16)));
                if (tick_i) mcnt++;
                if (mcnt == 16 * frame_len(cur)) mon_busy = 0;
            end
        end
    end

    task automatic wr(input logic [7:0] d);
        @(posedge clk); #1;
        wr_data_i  = d;
        wr_valid_i = 1'b1;
        if (hold_empty_o && tx_en_i)
            exp_q.push_back({nine_mode_i, nine_model, d});
        @(posedge clk); #1;
        wr_valid_i = 1'b0;
    endtask

    task automatic set_nine(input logic v);
        @(posedge clk); #1;
        nine_val_i = v;
        nine_wr_i  = 1'b1;
        nine_model = v;
        @(posedge clk); #1;
        nine_wr_i  = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk);
        while (!(shift_empty_o && hold_empty_o && !mon_busy && exp_q.size() == 0) && cyc < 140000);
    endtask

    always @(posedge clk) begin
        if (cyc == 150000 && !done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        chk(tx_o == 1'b1, "R1", "idle line after reset", int'(tx_o), 1);
        chk(hold_empty_o == 1'b1, "R1", "hold empty after reset", int'(hold_empty_o), 1);
        chk(shift_empty_o == 1'b1, "R1", "shift empty after reset", int'(shift_empty_o), 1);
        chk(irq_o == 1'b0, "R7", "irq masked", int'(irq_o), 0);
        irq_en_i = 1'b1;
        @(negedge clk);
        chk(irq_o == 1'b1, "R7", "irq with hold empty", int'(irq_o), 1);

        // Back-to-back 8-bit frames, third write into a full register dropped.
        tick_mode = 0;
        @(posedge clk); #1;
        wr_data_i = 8'h3C; wr_valid_i = 1'b1;
        exp_q.push_back({1'b0, nine_model, 8'h3C});
        @(posedge clk); #1; wr_valid_i = 1'b0;
        @(negedge clk);
        chk(hold_empty_o == 1'b0, "R5", "hold full after write", int'(hold_empty_o), 0);
        chk(irq_o == 1'b0, "R7", "irq drops with hold full", int'(irq_o), 0);
        @(negedge clk);
        chk(hold_empty_o == 1'b1, "R4", "handoff on tick", int'(hold_empty_o), 1);
        chk(shift_empty_o == 1'b0, "R6", "shifter busy at start", int'(shift_empty_o), 0);
        chk(tx_o == 1'b0, "R6", "start bit low", int'(tx_o), 0);
        wr(8'hA1);
        wr(8'h5E);
        chk(hold_empty_o == 1'b0, "R3", "second entry still pending", int'(hold_empty_o), 0);
        wait_idle();
        chk(n_frames == 2, "R3", "frame count with dropped write", n_frames, 2);
        chk(last_start - prev_start == 160, "R4", "gapless start spacing", last_start - prev_start, 160);
        chk(last_start - prev_start == 160, "R10", "8-bit frame is 10 bits", (last_start - prev_start) / 16, 10);

        // 9-bit frames: ninth bit captured at load.
        nine_mode_i = 1'b1;
        set_nine(1'b1);
        wr(8'h80);
        set_nine(1'b0);
        wr(8'h01);
        set_nine(1'b1);
        wait_idle();
        chk(last_start - prev_start == 176, "R8", "9-bit frame spacing", last_start - prev_start, 176);
        nine_mode_i = 1'b0;

        // Disable mid-frame.
        wr(8'hF0);
        repeat (40) @(negedge clk);
        @(posedge clk); #1 tx_en_i = 1'b0;
        @(negedge clk);
        chk(tx_oe_o == 1'b0, "R9", "driver released", int'(tx_oe_o), 0);
        exp_q.delete();
        @(negedge clk);
        chk(shift_empty_o == 1'b1, "R9", "shifter reset", int'(shift_empty_o), 1);
        chk(hold_empty_o == 1'b1, "R9", "holding cleared", int'(hold_empty_o), 1);
        wr(8'h11);
        @(negedge clk);
        chk(hold_empty_o == 1'b1, "R3", "write ignored while disabled", int'(hold_empty_o), 1);
        @(posedge clk); #1 tx_en_i = 1'b1;
        begin
            bit seen_low = 0;
            for (int i = 0; i < 200; i++) begin
                @(negedge clk);
                if (tx_o == 1'b0) seen_low = 1;
            end
            chk(!seen_low, "R9", "no resumed frame", int'(seen_low), 0);
            chk(tx_o == 1'b1, "R1", "idle high after re-enable", int'(tx_o), 1);
        end

        // Random frames with mixed tick density and frame length.
        for (int i = 0; i < 30; i++) begin
            tick_mode   = $urandom % 3;
            nine_mode_i = $urandom % 2;
            if ($urandom % 2) set_nine($urandom % 2);
            while (!hold_empty_o) @(negedge clk);
            wr(8'($urandom));
            repeat ($urandom % 40) @(negedge clk);
        end
        wait_idle();
        chk(exp_q.size() == 0, "R4", "all accepted frames sent", exp_q.size(), 0);
        chk(shift_empty_o == 1'b1, "R6", "shifter idle at end", int'(shift_empty_o), 1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule